// File: doc/BRIEF.md
# Interrupt Control Unit on Custom-0 Instructions

This unit sits beside a small 32-bit integer core. It carries out interrupt management through six instructions in the custom-0 opcode space, with no CSR accesses. The core passes an instruction word with a valid strobe and the value of the first source register. It holds that word until the unit raises `insn_done`. In the same cycle the unit returns the destination-register value and its write enable. Inside the unit are four scratch q-registers, a pending-interrupt register, an interrupt mask register and a down-counting cycle timer.

The unit collects three kinds of event into the pending register: timer expiry, illegal instruction and bus error. External interrupt lines feed the same register. When an unmasked interrupt is pending and no handler is running, the unit asks the core to enter the handler. When the core acknowledges, the unit saves the interrupted PC and the set of interrupts taken. The return instruction hands the saved PC back to the core and allows entry again. An illegal instruction or bus error that arrives while its own mask bit is set stops the core through a halt output.

Top module: `irqc_unit`

## Requirements
- R1: Only words whose bits [6:0] equal 0001011 are claimed. For any other word, `insn_done` and `rd_we` stay low and no internal state changes.
- R2: The operation is chosen by funct7 in bits [31:25]. Funct7 0000001 copies `rs1_val` into the q-register selected by bits [8:7], with no rd write. Funct7 0000000 returns the q-register selected by bits [16:15] on `rd_wdata`, with `rd_we` high. Completion is signalled in the cycle the word is presented, and state updates on that clock edge.
- R3: A claimed word is illegal in two cases: its funct7 is not one of 0000000 to 0000101, or it is a q-register transfer whose 5-bit index field has a nonzero bit in [4:2]. An illegal word completes with `rd_we` low and sets pending bit 1.
- R4: Funct7 0000011 writes `rs1_val` into the mask and returns the previous mask value. A set mask bit disables that interrupt. Reset leaves the mask all ones.
- R5: Funct7 0000101 loads `rs1_val` into the timer and returns the previous count. A nonzero count decrements once per clock. Only a step from 1 to 0 sets pending bit 0, and a load in that same cycle wins and raises nothing. A count of zero stays idle.
- R6: Funct7 0000100 holds `insn_done` low while the pending register is zero. Once it is nonzero, the instruction completes and returns the pending bitmask.
- R7: `irq_req` is high exactly when some pending bit is unmasked, no handler is active and the unit is not halted.
- R8: An `irq_ack` while `irq_req` is high does four things. It writes `entry_pc` into q0 and the taken bitmask (pending and not masked) into q1. It clears those pending bits and marks a handler active. A pending bit set in the same cycle is kept.
- R9: Funct7 0000010 completes with `ret_req` high, `ret_pc` equal to q0 and no rd write. It ends the active handler.
- R10: `halt` goes high the cycle after an illegal word (or `illegal_evt`) with mask bit 1 set, or a `bus_err_evt` with mask bit 2 set. It stays high until reset.
- R11: External line i sets pending bit i+3, and `bus_err_evt` sets bit 2. Pending bits stay set until an entry acknowledge takes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is presented and held until done |
| insn_word | input | 32 | Instruction word |
| rs1_val | input | 32 | First source register value |
| rd_wdata | output | 32 | Destination register value |
| rd_we | output | 1 | Destination register write enable |
| insn_done | output | 1 | Instruction completes this cycle |
| ext_irq | input | 29 | External interrupt lines, pending bits 3 to 31 |
| illegal_evt | input | 1 | Illegal instruction seen by the core |
| bus_err_evt | input | 1 | Bus error seen by the core |
| irq_req | output | 1 | Request to enter the interrupt handler |
| irq_ack | input | 1 | Core enters the handler this cycle |
| entry_pc | input | 32 | PC to resume after the handler |
| ret_req | output | 1 | Core must jump to `ret_pc` |
| ret_pc | output | 32 | Saved return address |
| halt | output | 1 | Core must stop |

## Verification
Two pairs of functions in this unit can act in the same clock edge, and each pair is forced to coincide.

The first pair is an entry acknowledge and a new interrupt. The bench raises an external line in the very cycle it acknowledges entry. A later wait instruction must then report the new bit pending while the taken timer bit is gone, and q1 must hold only the taken bit.

The second pair is a timer reload and the timer's final step. The bench issues a reload exactly when the count reads 1. It then checks that the old count comes back as 1 and that no timer pending bit appears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

    localparam logic [6:0] F7_GETQ  = 7'b0000000;
    localparam logic [6:0] F7_SETQ  = 7'b0000001;
    localparam logic [6:0] F7_RETI  = 7'b0000010;
    localparam logic [6:0] F7_MASK  = 7'b0000011;
    localparam logic [6:0] F7_WAIT  = 7'b0000100;
    localparam logic [6:0] F7_TIMER = 7'b0000101;

    localparam int BIT_TIMER   = 0;
    localparam int BIT_ILLEGAL = 1;
    localparam int BIT_BUSERR  = 2;
    localparam int NUM_INTERNAL = 3;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GETQ,
        OP_SETQ,
        OP_RETI,
        OP_MASK,
        OP_WAIT,
        OP_TIMER
    } op_e;

    typedef struct packed {
        logic       claim;
        logic       illegal;
        op_e        op;
        logic [4:0] src_field;
        logic [4:0] dst_field;
    } dec_t;

    function automatic logic op_writes_rd(op_e op);
        return (op == OP_GETQ) || (op == OP_MASK) ||
               (op == OP_WAIT) || (op == OP_TIMER);
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int QIDX_W = 2
) (
    input  logic [XLEN-1:0] word,
    output dec_t            dec
);
    localparam int FIELD_W = 5;

    logic [6:0] opcode;
    logic [6:0] funct7;
    logic       src_hi_bad;
    logic       dst_hi_bad;

    assign opcode = word[6:0];
    assign funct7 = word[31:25];
    assign src_hi_bad = (word[19:15] >> QIDX_W) != '0;
    assign dst_hi_bad = (word[11:7]  >> QIDX_W) != '0;

    always_comb begin
        dec           = '0;
        dec.op        = OP_NONE;
        dec.src_field = word[19:15];
        dec.dst_field = word[11:7];
        if (opcode == OPC_CUSTOM0) begin
            dec.claim = 1'b1;
            unique case (funct7)
                F7_GETQ: begin
                    dec.op      = OP_GETQ;
                    dec.illegal = src_hi_bad;
                end
                F7_SETQ: begin
                    dec.op      = OP_SETQ;
                    dec.illegal = dst_hi_bad;
                end
                F7_RETI:  dec.op = OP_RETI;
                F7_MASK:  dec.op = OP_MASK;
                F7_WAIT:  dec.op = OP_WAIT;
                F7_TIMER: dec.op = OP_TIMER;
                default: begin
                    dec.op      = OP_NONE;
                    dec.illegal = 1'b1;
                end
            endcase
        end
    end

    logic unused_w;
    assign unused_w = ^{FIELD_W[0], word[24:20], word[14:12]};

endmodule

// File: rtl/irqc_qregs.sv
module irqc_qregs #(
    parameter int XLEN   = 32,
    parameter int NQ     = 4,
    parameter int QIDX_W = $clog2(NQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [QIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              entry_en,
    input  logic [XLEN-1:0]   entry_pc,
    input  logic [XLEN-1:0]   entry_taken,
    input  logic [QIDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]   rd_data,
    output logic [XLEN-1:0]   q0_o
);
    logic [XLEN-1:0] q_r [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        always_ff @(posedge clk) begin
            if (rst) begin
                q_r[g] <= '0;
            end else if (entry_en && g == 0) begin
                q_r[g] <= entry_pc;
            end else if (entry_en && g == 1) begin
                q_r[g] <= entry_taken;
            end else if (wr_en && wr_idx == QIDX_W'(g)) begin
                q_r[g] <= wr_data;
            end
        end
    end

    assign rd_data = q_r[rd_idx];
    assign q0_o    = q_r[0];

endmodule

// File: rtl/irqc_timer.sv
module irqc_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_n;

    always_comb begin
        if (load_en)
            cnt_n = load_val;
        else if (cnt_q != '0)
            cnt_n = cnt_q - W'(1);
        else
            cnt_n = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_n;
    end

    assign count_o  = cnt_q;
    assign expire_o = !load_en && (cnt_q == W'(1));

endmodule

// File: rtl/irqc_irq_ctl.sv
module irqc_irq_ctl
    import irqc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] set_vec,
    input  logic            illegal_now,
    input  logic            buserr_now,
    input  logic            mask_we,
    input  logic [XLEN-1:0] mask_wdata,
    input  logic            ack,
    input  logic            reti,
    output logic [XLEN-1:0] pend_o,
    output logic [XLEN-1:0] mask_o,
    output logic [XLEN-1:0] taken_o,
    output logic            req_o,
    output logic            take_o,
    output logic            in_hdl_o,
    output logic            halt_o
);
    logic [XLEN-1:0] pend_q, mask_q;
    logic            in_hdl_q, halt_q;
    logic            halt_set;

    assign taken_o  = pend_q & ~mask_q;
    assign req_o    = (taken_o != '0) && !in_hdl_q && !halt_q;
    assign take_o   = req_o && ack;
    assign halt_set = (illegal_now && mask_q[BIT_ILLEGAL]) ||
                      (buserr_now  && mask_q[BIT_BUSERR]);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            mask_q   <= '1;
            in_hdl_q <= 1'b0;
            halt_q   <= 1'b0;
        end else begin
            pend_q <= (take_o ? (pend_q & ~taken_o) : pend_q) | set_vec;
            if (mask_we) mask_q <= mask_wdata;
            if (take_o)    in_hdl_q <= 1'b1;
            else if (reti) in_hdl_q <= 1'b0;
            if (halt_set)  halt_q <= 1'b1;
        end
    end

    assign pend_o   = pend_q;
    assign mask_o   = mask_q;
    assign in_hdl_o = in_hdl_q;
    assign halt_o   = halt_q;

endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NQ   = 4,
    localparam int QIDX_W = $clog2(NQ),
    localparam int NEXT   = XLEN - NUM_INTERNAL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            insn_valid,
    input  logic [XLEN-1:0] insn_word,
    input  logic [XLEN-1:0] rs1_val,
    output logic [XLEN-1:0] rd_wdata,
    output logic            rd_we,
    output logic            insn_done,
    input  logic [NEXT-1:0] ext_irq,
    input  logic            illegal_evt,
    input  logic            bus_err_evt,
    output logic            irq_req,
    input  logic            irq_ack,
    input  logic [XLEN-1:0] entry_pc,
    output logic            ret_req,
    output logic [XLEN-1:0] ret_pc,
    output logic            halt
);
    dec_t            dec;
    logic            can_finish;
    logic            commit;
    logic            legal_commit;
    logic [XLEN-1:0] q_rdata;
    logic [XLEN-1:0] q0_val;
    logic [XLEN-1:0] tmr_count;
    logic            tmr_load;
    logic            tmr_expire;
    logic [XLEN-1:0] pend_q;
    logic [XLEN-1:0] mask_q;
    logic [XLEN-1:0] taken;
    logic            take;
    logic            in_hdl;
    logic            illegal_now;
    logic [XLEN-1:0] set_vec;

    irqc_decode #(.XLEN(XLEN), .QIDX_W(QIDX_W)) u_dec (
        .word (insn_word),
        .dec  (dec)
    );

    assign can_finish   = dec.claim && (dec.op != OP_WAIT || pend_q != '0);
    assign insn_done    = insn_valid && can_finish;
    assign commit       = insn_done;
    assign legal_commit = commit && !dec.illegal;

    irqc_qregs #(.XLEN(XLEN), .NQ(NQ)) u_q (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (legal_commit && dec.op == OP_SETQ),
        .wr_idx      (dec.dst_field[QIDX_W-1:0]),
        .wr_data     (rs1_val),
        .entry_en    (take),
        .entry_pc    (entry_pc),
        .entry_taken (taken),
        .rd_idx      (dec.src_field[QIDX_W-1:0]),
        .rd_data     (q_rdata),
        .q0_o        (q0_val)
    );

    assign tmr_load = legal_commit && dec.op == OP_TIMER;

    irqc_timer #(.W(XLEN)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load_en  (tmr_load),
        .load_val (rs1_val),
        .count_o  (tmr_count),
        .expire_o (tmr_expire)
    );

    assign illegal_now = (commit && dec.illegal) || illegal_evt;

    always_comb begin
        set_vec              = '0;
        set_vec[BIT_TIMER]   = tmr_expire;
        set_vec[BIT_ILLEGAL] = illegal_now;
        set_vec[BIT_BUSERR]  = bus_err_evt;
        set_vec[XLEN-1:NUM_INTERNAL] = ext_irq;
    end

    irqc_irq_ctl #(.XLEN(XLEN)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .set_vec     (set_vec),
        .illegal_now (illegal_now),
        .buserr_now  (bus_err_evt),
        .mask_we     (legal_commit && dec.op == OP_MASK),
        .mask_wdata  (rs1_val),
        .ack         (irq_ack),
        .reti        (legal_commit && dec.op == OP_RETI),
        .pend_o      (pend_q),
        .mask_o      (mask_q),
        .taken_o     (taken),
        .req_o       (irq_req),
        .take_o      (take),
        .in_hdl_o    (in_hdl),
        .halt_o      (halt)
    );

    always_comb begin
        unique case (dec.op)
            OP_GETQ:  rd_wdata = q_rdata;
            OP_MASK:  rd_wdata = mask_q;
            OP_TIMER: rd_wdata = tmr_count;
            OP_WAIT:  rd_wdata = pend_q;
            default:  rd_wdata = '0;
        endcase
    end

    assign rd_we   = legal_commit && op_writes_rd(dec.op);
    assign ret_req = legal_commit && dec.op == OP_RETI;
    assign ret_pc  = q0_val;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            insn_valid,
    input logic [XLEN-1:0] insn_word,
    input logic            insn_done,
    input logic            rd_we,
    input logic            irq_req,
    input logic            irq_ack,
    input logic [XLEN-1:0] entry_pc,
    input logic            ret_req,
    input logic            halt,
    input logic [XLEN-1:0] tmr_count,
    input logic            tmr_load,
    input logic [XLEN-1:0] pend_q,
    input logic            in_hdl,
    input logic [XLEN-1:0] q0_val
);
    logic is_custom;
    logic is_wait;
    assign is_custom = insn_word[6:0] == 7'b0001011;
    assign is_wait   = is_custom && insn_word[31:25] == 7'b0000100;

    // R1
    foreign_word_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !is_custom) |-> (!insn_done && !rd_we));

    // R5
    timer_expire_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_count == XLEN'(1) && !tmr_load) |=> pend_q[0]);

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && is_wait && pend_q == '0) |-> !insn_done);

    // R7
    no_nested_entry_chk: assert property (@(posedge clk) disable iff (rst)
        in_hdl |-> !irq_req);

    // R8
    entry_save_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> (q0_val == $past(entry_pc) && in_hdl));

    // R9
    return_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !(irq_req && irq_ack)) |=> !in_hdl);

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

endmodule

bind irqc_unit irqc_chk #(.XLEN(XLEN)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .insn_done  (insn_done),
    .rd_we      (rd_we),
    .irq_req    (irq_req),
    .irq_ack    (irq_ack),
    .entry_pc   (entry_pc),
    .ret_req    (ret_req),
    .halt       (halt),
    .tmr_count  (tmr_count),
    .tmr_load   (tmr_load),
    .pend_q     (pend_q),
    .in_hdl     (in_hdl),
    .q0_val     (q0_val)
);

// File: tb/irqc_unit_tb_top.sv
module irqc_unit_tb_top;

    localparam int XLEN = 32;
    localparam int NEXT = XLEN - 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            insn_valid;
    logic [XLEN-1:0] insn_word;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] rd_wdata;
    logic            rd_we;
    logic            insn_done;
    logic [NEXT-1:0] ext_irq;
    logic            illegal_evt;
    logic            bus_err_evt;
    logic            irq_req;
    logic            irq_ack;
    logic [XLEN-1:0] entry_pc;
    logic            ret_req;
    logic [XLEN-1:0] ret_pc;
    logic            halt;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irqc_unit #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
        .rs1_val(rs1_val), .rd_wdata(rd_wdata), .rd_we(rd_we),
        .insn_done(insn_done), .ext_irq(ext_irq), .illegal_evt(illegal_evt),
        .bus_err_evt(bus_err_evt), .irq_req(irq_req), .irq_ack(irq_ack),
        .entry_pc(entry_pc), .ret_req(ret_req), .ret_pc(ret_pc), .halt(halt)
    );

    function automatic logic [31:0] enc(logic [6:0] f7, logic [4:0] src, logic [4:0] dst);
        return {f7, 5'd0, src, 3'd0, dst, 7'b0001011};
    endfunction

    typedef struct packed {
        logic [31:0] word;
        logic [31:0] rs1;
        logic        we;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{enc(7'd1, 5'd0, 5'd2), 32'hA5A5_0001, 1'b0, 32'h0},
        '{enc(7'd0, 5'd2, 5'd1), 32'h0,         1'b1, 32'hA5A5_0001},
        '{enc(7'd1, 5'd0, 5'd3), 32'h0000_1234, 1'b0, 32'h0},
        '{enc(7'd0, 5'd3, 5'd1), 32'h0,         1'b1, 32'h0000_1234},
        '{enc(7'd3, 5'd0, 5'd1), 32'hFFFF_FFF0, 1'b1, 32'hFFFF_FFFF},
        '{enc(7'd3, 5'd0, 5'd1), 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFF0},
        '{enc(7'd5, 5'd0, 5'd1), 32'd100,       1'b1, 32'd0},
        '{enc(7'd5, 5'd0, 5'd1), 32'd0,         1'b1, 32'd100}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic        s_done, s_we, s_ret;
    logic [31:0] s_rd, s_rpc;

    // Called at a negedge; samples combinational outputs, commits at the next posedge.
    task automatic op(logic [31:0] w, logic [31:0] r1);
        insn_valid = 1'b1;
        insn_word  = w;
        rs1_val    = r1;
        #1;
        s_done = insn_done; s_we = rd_we; s_rd = rd_wdata;
        s_ret  = ret_req;   s_rpc = ret_pc;
        @(posedge clk);
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack(logic [31:0] pc, logic [NEXT-1:0] lines);
        irq_ack  = 1'b1;
        entry_pc = pc;
        ext_irq  = lines;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
        ext_irq = '0;
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; insn_valid = 1'b0; insn_word = '0; rs1_val = '0;
        ext_irq = '0; illegal_evt = 1'b0; bus_err_evt = 1'b0;
        irq_ack = 1'b0; entry_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R7 reset irq_req", 32'(irq_req), 32'd0);
        check("R10 reset halt", 32'(halt), 32'd0);
        check("R9 reset ret_req", 32'(ret_req), 32'd0);
        @(negedge clk);

        // Table: R2 q transfers, R4 mask swap with reset value, R5 timer swap
        for (int i = 0; i < NV; i++) begin
            op(VECS[i].word, VECS[i].rs1);
            check($sformatf("R2/R4/R5 vec%0d done", i), 32'(s_done), 32'd1);
            check($sformatf("R2/R4/R5 vec%0d we", i), 32'(s_we), 32'(VECS[i].we));
            if (VECS[i].we)
                check($sformatf("R2/R4/R5 vec%0d rd", i), s_rd, VECS[i].rd);
        end

        // R1: foreign opcodes ignored
        op(32'h0000_0033, 32'h0);
        check("R1 op-opcode done", 32'(s_done), 32'd0);
        check("R1 op-opcode we", 32'(s_we), 32'd0);
        op({7'd1, 5'd0, 5'd0, 3'd0, 5'd2, 7'b0101011}, 32'hDEAD_BEEF);
        check("R1 custom1 done", 32'(s_done), 32'd0);
        op(enc(7'd0, 5'd2, 5'd1), 32'h0);
        check("R1 q2 untouched", s_rd, 32'hA5A5_0001);

        // R5/R6: timer expiry and wait stall
        op(enc(7'd5, 5'd0, 5'd1), 32'd3);
        insn_valid = 1'b1; insn_word = enc(7'd4, 5'd0, 5'd1); rs1_val = '0;
        for (int k = 0; k < 3; k++) begin
            #1 check("R6 wait stalls", 32'(insn_done), 32'd0);
            @(negedge clk);
        end
        #1;
        check("R6 wait done", 32'(insn_done), 32'd1);
        check("R5 R6 pending timer bit", rd_wdata, 32'h1);
        check("R6 wait we", 32'(rd_we), 32'd1);
        @(posedge clk); @(negedge clk); insn_valid = 1'b0;
        #1 check("R7 masked no req", 32'(irq_req), 32'd0);

        // R7/R8: entry
        op(enc(7'd3, 5'd0, 5'd1), 32'hFFFF_FFFE);
        check("R4 old mask", s_rd, 32'hFFFF_FFFF);
        #1 check("R7 unmasked req", 32'(irq_req), 32'd1);
        do_ack(32'h8000_0040, '0);
        #1 check("R8 req cleared", 32'(irq_req), 32'd0);
        op(enc(7'd0, 5'd0, 5'd1), 32'h0);
        check("R8 q0 pc", s_rd, 32'h8000_0040);
        op(enc(7'd0, 5'd1, 5'd1), 32'h0);
        check("R8 q1 taken", s_rd, 32'h1);
        op(enc(7'd5, 5'd0, 5'd1), 32'd1);
        idle(2);
        #1 check("R7 blocked in handler", 32'(irq_req), 32'd0);

        // R9: return
        op(enc(7'd2, 5'd0, 5'd0), 32'h0);
        check("R9 ret_req", 32'(s_ret), 32'd1);
        check("R9 ret_pc", s_rpc, 32'h8000_0040);
        check("R9 no rd write", 32'(s_we), 32'd0);
        #1 check("R9 entry re-enabled", 32'(irq_req), 32'd1);

        // R8/R11: ack coincides with a new external line
        do_ack(32'h0000_2000, NEXT'(1));
        op(enc(7'd4, 5'd0, 5'd1), 32'h0);
        check("R8 R11 new bit kept", s_rd, 32'h8);
        op(enc(7'd0, 5'd1, 5'd1), 32'h0);
        check("R8 q1 only taken", s_rd, 32'h1);

        // R5: load in the final-step cycle
        op(enc(7'd5, 5'd0, 5'd1), 32'd2);
        idle(1);
        op(enc(7'd5, 5'd0, 5'd1), 32'd50);
        check("R5 count at reload", s_rd, 32'd1);
        op(enc(7'd5, 5'd0, 5'd1), 32'd0);
        check("R5 reload value", s_rd, 32'd50);
        op(enc(7'd4, 5'd0, 5'd1), 32'h0);
        check("R5 no expiry on reload", s_rd, 32'h8);

        // R3/R11: illegal and bus error unmasked
        op(enc(7'd2, 5'd0, 5'd0), 32'h0);
        check("R9 ret_pc second", s_rpc, 32'h0000_2000);
        op(enc(7'd3, 5'd0, 5'd1), 32'hFFFF_FFF8);
        check("R4 old mask 2", s_rd, 32'hFFFF_FFFE);
        op(enc(7'd7, 5'd0, 5'd1), 32'h0);
        check("R3 illegal done", 32'(s_done), 32'd1);
        check("R3 illegal no we", 32'(s_we), 32'd0);
        #1 check("R3 illegal requests", 32'(irq_req), 32'd1);
        check("R10 no halt unmasked", 32'(halt), 32'd0);
        bus_err_evt = 1'b1; @(posedge clk); @(negedge clk); bus_err_evt = 1'b0;
        do_ack(32'h0000_3000, '0);
        op(enc(7'd0, 5'd1, 5'd1), 32'h0);
        check("R3 R11 q1 illegal+buserr", s_rd, 32'h6);
        op(enc(7'd2, 5'd0, 5'd0), 32'h0);

        // R10: masked illegal halts
        op(enc(7'd3, 5'd0, 5'd1), 32'hFFFF_FFFF);
        check("R4 old mask 3", s_rd, 32'hFFFF_FFF8);
        op(enc(7'd0, 5'd9, 5'd1), 32'h0);
        check("R3 bad index done", 32'(s_done), 32'd1);
        check("R3 bad index no we", 32'(s_we), 32'd0);
        #1 check("R10 halt raised", 32'(halt), 32'd1);
        check("R10 no req when halted", 32'(irq_req), 32'd0);
        idle(2);
        #1 check("R10 halt sticky", 32'(halt), 32'd1);

        summary();
        $finish;
    end

endmodule